// File: doc/BRIEF.md
# Half-Duplex Collision Detector

This block produces the collision indication that a twisted-pair PHY presents to its MAC. It watches the MAC transmit enable and a receive-activity flag, and it raises the collision output when both are active together on a half-duplex link. The receive-activity flag is produced upstream. At 100 Mbps it reports non-idle symbols on the line input. At 10 Mbps it reports that the squelch is open. Collision is suppressed while the port runs full duplex, while the link has failed, or while diagnostic loopback is selected. During a collision the block does not stop any traffic, and the MACs are left to end their own frames.

At 10 Mbps the block does three further things. During a collision it drives a control that zeroes the receive data handed to the MAC. It also reports collision during an externally timed SQE-test window, and whenever the jabber flag is up. A collision-test control bit sends transmit enable straight to the collision output and disables the line drivers. This test path takes priority over the duplex, link and loopback gating.

A five-state machine with registered state drives all outputs. The state names are `CD_ARMED`, `CD_GATED`, `CD_OVERLAP`, `CD_SIDEBAND` and `CD_LOOPTEST`. On every clock edge the next state is chosen from the current inputs, in this priority order:
1. Test bit set: `CD_LOOPTEST`.
2. Any gating mode active: `CD_GATED`.
3. Transmit and receive both active: `CD_OVERLAP`.
4. At 10 Mbps, SQE window or jabber: `CD_SIDEBAND`.
5. Otherwise: `CD_ARMED`.

Any state can move to any other state on one edge. Every output therefore follows its inputs with a latency of exactly one clock.

Top module: `col_detect`

## Requirements
- R1: When `col_test`=0, `full_dup`=0, `link_fail`=0, `diag_lpbk`=0, and `tx_en`=1 with `rx_act`=1 at a rising edge, `col` is 1 after that edge. This holds at either speed.
- R2: `col` returns to 0 after the first edge at which the collision condition has gone false, with no hold-over cycles.
- R3: With `col_test`=0, any one of `full_dup`, `link_fail` or `diag_lpbk` being 1 at an edge makes `col`=0 after that edge, whatever the activity, SQE or jabber inputs are.
- R4: `rx_zero` is 1 after an edge exactly when that edge saw an R1 overlap with `spd_100`=0 (10 Mbps). It is 0 at 100 Mbps and in every other case.
- R5: With `spd_100`=0, `col_test`=0 and no gating mode active, `sqe_win`=1 or `jabber`=1 at an edge makes `col`=1 after it. With `spd_100`=1 these two inputs are ignored, and this is checked on `col`.
- R6: With `col_test`=1 at an edge, after that edge `col` equals the `tx_en` value sampled at that edge and `tx_out_dis`=1, whatever the gating modes are.
- R7: `tx_out_dis` is 0 after any edge at which `col_test`=0.
- R8: While `rst_n`=0 (asynchronous, active low), `col`, `tx_out_dis` and `rx_zero` are all 0.
- R9: In half duplex with no SQE or jabber, `tx_en` alone or `rx_act` alone leaves `col`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | MII-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | MAC transmit enable |
| rx_act | input | 1 | Receive activity (non-idle at 100M, squelch open at 10M) |
| spd_100 | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| full_dup | input | 1 | 1 = full duplex |
| link_fail | input | 1 | 1 = link in fail state |
| diag_lpbk | input | 1 | 1 = diagnostic loopback |
| sqe_win | input | 1 | SQE-test window, generated outside the block |
| jabber | input | 1 | Jabber condition detected |
| col_test | input | 1 | Collision-test control bit |
| col | output | 1 | Collision indication to the MAC |
| tx_out_dis | output | 1 | Disable for the twisted-pair transmit drivers |
| rx_zero | output | 1 | Forces 10 Mbps receive data to zero |

## Verification
The hardest situation to reach is a clash of priorities. Examples are the test bit set while a gating mode is also active, or an overlap at 10 Mbps arriving together with jabber. In the second case `rx_zero` must still follow the overlap and not the sideband. The stimulus is a full sweep of all 512 combinations of the nine control and activity inputs, one combination per clock. Each result is compared one edge later, so every priority collision occurs. A separate directed sequence covers the release edge and the reset state.

// File: rtl/col_pkg.sv
package col_pkg;
    typedef enum logic [2:0] {
        CD_ARMED    = 3'd0,
        CD_GATED    = 3'd1,
        CD_OVERLAP  = 3'd2,
        CD_SIDEBAND = 3'd3,
        CD_LOOPTEST = 3'd4
    } cd_state_e;
endpackage

// File: rtl/cd_mode_gate.sv
module cd_mode_gate (
    input  logic full_dup,
    input  logic link_fail,
    input  logic diag_lpbk,
    input  logic col_test,
    output logic gate_off,
    output logic test_on
);
    // Any one blocking mode suppresses normal collision reporting.
    assign gate_off = full_dup | link_fail | diag_lpbk;
    assign test_on  = col_test;
endmodule

// File: rtl/cd_activity.sv
module cd_activity (
    input  logic tx_en,
    input  logic rx_act,
    input  logic spd_100,
    input  logic sqe_win,
    input  logic jabber,
    output logic overlap,
    output logic sideband
);
    // Transmit and receive activity present together.
    assign overlap  = tx_en & rx_act;
    // 10 Mbps-only reasons to raise collision.
    assign sideband = ~spd_100 & (sqe_win | jabber);
endmodule

// File: rtl/cd_fsm.sv
module cd_fsm
    import col_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic test_on,
    input  logic gate_off,
    input  logic overlap,
    input  logic sideband,
    input  logic tx_en,
    input  logic spd_100,
    output logic col,
    output logic tx_out_dis,
    output logic rx_zero
);
    cd_state_e state_q, state_d;
    logic      tx_q;
    logic      slow_q;

    // Next-state selection: fixed priority, reachable from every state.
    always_comb begin
        if (test_on)       state_d = CD_LOOPTEST;
        else if (gate_off) state_d = CD_GATED;
        else if (overlap)  state_d = CD_OVERLAP;
        else if (sideband) state_d = CD_SIDEBAND;
        else               state_d = CD_ARMED;
    end

    // State register plus the sampled values the outputs depend on.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CD_ARMED;
            tx_q    <= 1'b0;
            slow_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            tx_q    <= tx_en;
            slow_q  <= ~spd_100;
        end
    end

    // Output decode from registered state only.
    always_comb begin
        col        = 1'b0;
        tx_out_dis = 1'b0;
        rx_zero    = 1'b0;
        unique case (state_q)
            CD_ARMED:    ;
            CD_GATED:    ;
            CD_OVERLAP: begin
                col     = 1'b1;
                rx_zero = slow_q;
            end
            CD_SIDEBAND: col = 1'b1;
            CD_LOOPTEST: begin
                col        = tx_q;
                tx_out_dis = 1'b1;
            end
            default: ;
        endcase
    end

    // Zeroing only accompanies an active collision.
    p_zero_needs_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_zero |-> col);
    // Driver disable and zeroing never coexist.
    p_dis_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_out_dis && rx_zero));
endmodule

// File: rtl/col_detect.sv
module col_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic rx_act,
    input  logic spd_100,
    input  logic full_dup,
    input  logic link_fail,
    input  logic diag_lpbk,
    input  logic sqe_win,
    input  logic jabber,
    input  logic col_test,
    output logic col,
    output logic tx_out_dis,
    output logic rx_zero
);
    logic gate_off, test_on, overlap, sideband;

    cd_mode_gate u_gate (
        .full_dup (full_dup),
        .link_fail(link_fail),
        .diag_lpbk(diag_lpbk),
        .col_test (col_test),
        .gate_off (gate_off),
        .test_on  (test_on)
    );

    cd_activity u_act (
        .tx_en   (tx_en),
        .rx_act  (rx_act),
        .spd_100 (spd_100),
        .sqe_win (sqe_win),
        .jabber  (jabber),
        .overlap (overlap),
        .sideband(sideband)
    );

    cd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_on   (test_on),
        .gate_off  (gate_off),
        .overlap   (overlap),
        .sideband  (sideband),
        .tx_en     (tx_en),
        .spd_100   (spd_100),
        .col       (col),
        .tx_out_dis(tx_out_dis),
        .rx_zero   (rx_zero)
    );

    p_overlap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_test && !full_dup && !link_fail && !diag_lpbk && tx_en && rx_act) |=> col);

    p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_test && !(tx_en && rx_act) && !(!spd_100 && (sqe_win || jabber))) |=> !col);

    p_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_test && (full_dup || link_fail || diag_lpbk)) |=> !col);

    p_fast_nozero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        spd_100 |=> !rx_zero);

    p_sideband_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_test && !full_dup && !link_fail && !diag_lpbk && !spd_100 && (sqe_win || jabber)) |=> col);

    p_looptest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        col_test |=> (tx_out_dis && (col == $past(tx_en))));

    p_txdis_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !col_test |=> !tx_out_dis);
endmodule

// File: tb/col_detect_test.sv
`timescale 1ns/1ps
module col_detect_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 0, rx_act = 0, spd_100 = 0, full_dup = 0, link_fail = 0;
    logic diag_lpbk = 0, sqe_win = 0, jabber = 0, col_test = 0;
    logic col, tx_out_dis, rx_zero;
    int   n_chk = 0;
    int   n_fail = 0;
    int   cycles = 0;
    bit   done = 0;

    always #2.5 clk = ~clk;

    col_detect uut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_act(rx_act),
        .spd_100(spd_100), .full_dup(full_dup), .link_fail(link_fail),
        .diag_lpbk(diag_lpbk), .sqe_win(sqe_win), .jabber(jabber),
        .col_test(col_test), .col(col), .tx_out_dis(tx_out_dis),
        .rx_zero(rx_zero)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=5000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic e_col, e_dis, e_zero, blocked, both, side;
        string tcol;
        // R8: reset state
        #1;
        chk("R8", "col", col, 1'b0);
        chk("R8", "tx_out_dis", tx_out_dis, 1'b0);
        chk("R8", "rx_zero", rx_zero, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Exhaustive sweep of all nine control inputs.
        for (int v = 0; v < 512; v++) begin
            {col_test, jabber, sqe_win, diag_lpbk, link_fail, full_dup, spd_100, rx_act, tx_en} = v[8:0];
            blocked = full_dup | link_fail | diag_lpbk;
            both    = tx_en & rx_act;
            side    = !spd_100 & (sqe_win | jabber);
            if (col_test) begin
                e_col = tx_en; e_dis = 1; e_zero = 0; tcol = "R6";
            end else if (blocked) begin
                e_col = 0; e_dis = 0; e_zero = 0; tcol = "R3";
            end else if (both) begin
                e_col = 1; e_dis = 0; e_zero = !spd_100; tcol = "R1";
            end else if (side) begin
                e_col = 1; e_dis = 0; e_zero = 0; tcol = "R5";
            end else begin
                e_col = 0; e_dis = 0; e_zero = 0;
                tcol = (sqe_win | jabber) ? "R5" : "R9";
            end
            @(negedge clk);
            chk(tcol, "col", col, e_col);
            chk(col_test ? "R6" : "R7", "tx_out_dis", tx_out_dis, e_dis);
            chk("R4", "rx_zero", rx_zero, e_zero);
        end

        // R2: release on the first edge after the overlap ends.
        {col_test, jabber, sqe_win, diag_lpbk, link_fail, full_dup, spd_100, rx_act, tx_en} = 9'b0_0000_0011;
        @(negedge clk);
        chk("R2", "col during overlap", col, 1'b1);
        tx_en = 1'b0;
        @(negedge clk);
        chk("R2", "col after release", col, 1'b0);
        chk("R2", "rx_zero after release", rx_zero, 1'b0);

        // R8: asynchronous reset mid-collision.
        tx_en = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R8", "col in reset", col, 1'b0);
        chk("R8", "rx_zero in reset", rx_zero, 1'b0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule